// File: doc/BRIEF.md
# Indexed Codec Control Register Port

This block is the control-register front end of an audio codec. A simple bus with an address, a write enable, write data and a read strobe reaches a 64-byte window of sixteen 32-bit direct words. Word 0 holds a pointer whose low five bits pick one of thirty-two byte-wide indirect registers. Word 1 is a data port that reads and writes the indirect register the pointer selects.

The indirect file holds two fixed identification bytes. Some of its entries ignore writes, one keeps only a single writable bit, and one always reads as zero. A control word gives software a soft reset: setting bit 0 of that word clears the whole register state and restores the identification bytes. The same write then stores its masked value in the control word. Read data is registered and appears on the cycle after the read strobe. The interrupt output is held low.

Top module: `codec_ctrl_regs`

## Requirements
- R1: A write to word offset 0, 3 or 5 through 15 stores all 32 bits. A read strobe at that word returns the stored value on `bus_rdata` in the following cycle. `bus_rdata` holds its value when no read strobe is given.
- R2: Only bits [4:0] of word 0 select the indirect register. Word 0 still reads back all 32 written bits.
- R3: A write to word 1 stores bits [7:0] of the write data in the selected indirect register. A read of word 1 returns that byte in bits [7:0], with bits [31:8] zero.
- R4: A read of word 1 while the pointer is 3 returns zero, whatever was written there.
- R5: Writes to indirect registers 11 and 25 have no effect. They keep their reset values of 0x00 and 0xA0.
- R6: A write to indirect register 12 stores the value 0x8A ORed with bit 6 of the write data.
- R7: After reset, every direct word and every indirect register reads as zero, except indirect 12, which reads 0x8A, and indirect 25, which reads 0xA0. `bus_rdata` is zero.
- R8: Writes to word offset 2 are dropped, so that word always reads zero.
- R9: A write to word offset 4 with bit 0 set raises `soft_rst_o` during the write cycle. It restores every register to its R7 state and stores write data AND 0x7F in word 4, all in the same cycle.
- R10: A write to word offset 4 with bit 0 clear stores write data AND 0x7F in word 4 and leaves every other register unchanged.
- R11: `irq_o` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address within the window (bits [1:0] ignored) |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| soft_rst_o | output | 1 | High during a write cycle that triggers the soft reset |
| irq_o | output | 1 | Interrupt request, tied low |

## Verification
A corrupted pointer in word 0 appears at the data port on the next read of word 1, because the wrong byte comes back one cycle after the strobe. A protected or identification byte that has been overwritten is visible on the first read that points at it. A soft reset that misses a register leaves a stale value in that word, which shows on its next read.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
   // Direct word roles (word index = byte address >> 2)
   localparam int PTR_WORD   = 0;
   localparam int PORT_WORD  = 1;
   localparam int DROP_WORD  = 2;
   localparam int CTRL_WORD  = 4;
   // Indirect entries with special handling
   localparam int RAZ_IDX    = 3;
   localparam int LOCK_IDX_A = 11;
   localparam int ID_IDX     = 12;
   localparam int LOCK_IDX_B = 25;
   // Fixed values and masks
   localparam logic [7:0]  ID_CODEC  = 8'h8A;
   localparam logic [7:0]  ID_VERS   = 8'hA0;
   localparam logic [7:0]  ID_KEEP   = 8'h40;
   localparam logic [31:0] CTRL_KEEP = 32'h0000_007F;

   function automatic logic [7:0] ind_reset_val(input int idx);
      if (idx == ID_IDX)          return ID_CODEC;
      else if (idx == LOCK_IDX_B) return ID_VERS;
      else                        return 8'h00;
   endfunction
endpackage

// File: rtl/codec_bus_decode.sv
module codec_bus_decode
   import codec_regs_pkg::*;
#(
   parameter int DW      = 32,
   parameter int DIR_NUM = 16,
   localparam int WSEL_W = $clog2(DIR_NUM),
   localparam int ADDR_W = WSEL_W + 2
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [DW-1:0]     wdata_i,
   output logic [WSEL_W-1:0] word_o,
   output logic [DIR_NUM-1:0] dir_we_o,
   output logic              port_we_o,
   output logic              soft_rst_o
);
   logic [1:0] unused_lsb;
   assign unused_lsb = addr_i[1:0];
   assign word_o     = addr_i[ADDR_W-1:2];

   for (genvar i = 0; i < DIR_NUM; i++) begin : g_we
      assign dir_we_o[i] = we_i && (word_o == WSEL_W'(i));
   end

   assign port_we_o  = dir_we_o[PORT_WORD];
   assign soft_rst_o = dir_we_o[CTRL_WORD] && wdata_i[0];
endmodule

// File: rtl/codec_direct_regs.sv
module codec_direct_regs
   import codec_regs_pkg::*;
#(
   parameter int DW      = 32,
   parameter int DIR_NUM = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst_i,
   input  logic [DIR_NUM-1:0] dir_we_i,
   input  logic [DW-1:0]      wdata_i,
   output logic [DW-1:0]      words_o [DIR_NUM]
);
   for (genvar i = 0; i < DIR_NUM; i++) begin : g_word
      if (i == DROP_WORD || i == PORT_WORD) begin : g_none
         // no storage: writes dropped or steered to the indirect file
         logic unused_we;
         assign unused_we = dir_we_i[i];
         assign words_o[i] = '0;
      end else if (i == CTRL_WORD) begin : g_ctrl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              words_o[i] <= '0;
            else if (dir_we_i[i])    words_o[i] <= wdata_i & DW'(CTRL_KEEP);
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              words_o[i] <= '0;
            else if (soft_rst_i)     words_o[i] <= '0;
            else if (dir_we_i[i])    words_o[i] <= wdata_i;
         end
      end
   end

   // R9: soft reset clears the pointer word in the same cycle
   a_r9_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_i |=> (words_o[PTR_WORD] == '0));
   // R10: control word keeps only its masked bits
   a_r10_ctrl_mask: assert property (@(posedge clk) disable iff (!rst_n)
      dir_we_i[CTRL_WORD] |=> (words_o[CTRL_WORD] == ($past(wdata_i) & DW'(CTRL_KEEP))));
endmodule

// File: rtl/codec_indirect_regs.sv
module codec_indirect_regs
   import codec_regs_pkg::*;
#(
   parameter int IND_NUM = 32,
   parameter int IND_W   = 8,
   localparam int IDX_W  = $clog2(IND_NUM)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst_i,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [IND_W-1:0] wdata_i,
   output logic [IND_W-1:0] bytes_o [IND_NUM]
);
   for (genvar i = 0; i < IND_NUM; i++) begin : g_ind
      localparam logic [IND_W-1:0] RST_V = IND_W'(ind_reset_val(i));
      logic hit;
      assign hit = wr_en_i && (idx_i == IDX_W'(i));
      if (i == LOCK_IDX_A || i == LOCK_IDX_B) begin : g_lock
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          bytes_o[i] <= RST_V;
            else if (soft_rst_i) bytes_o[i] <= RST_V;
         end
         logic unused_hit;
         assign unused_hit = hit;
      end else if (i == ID_IDX) begin : g_id
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          bytes_o[i] <= RST_V;
            else if (soft_rst_i) bytes_o[i] <= RST_V;
            else if (hit)        bytes_o[i] <= (wdata_i & IND_W'(ID_KEEP)) | IND_W'(ID_CODEC);
         end
      end else begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          bytes_o[i] <= RST_V;
            else if (soft_rst_i) bytes_o[i] <= RST_V;
            else if (hit)        bytes_o[i] <= wdata_i;
         end
      end
   end

   // R5: locked entries hold across writes
   a_r5_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !soft_rst_i && idx_i == IDX_W'(LOCK_IDX_A)) |=> $stable(bytes_o[LOCK_IDX_A]));
   // R6: identification entry never loses its fixed bits
   a_r6_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (bytes_o[ID_IDX] & ~IND_W'(ID_KEEP)) == IND_W'(ID_CODEC));
endmodule

// File: rtl/codec_ctrl_regs.sv
module codec_ctrl_regs
   import codec_regs_pkg::*;
#(
   parameter int DW      = 32,
   parameter int DIR_NUM = 16,
   parameter int IND_NUM = 32,
   parameter int IND_W   = 8,
   localparam int WSEL_W = $clog2(DIR_NUM),
   localparam int ADDR_W = WSEL_W + 2,
   localparam int IDX_W  = $clog2(IND_NUM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DW-1:0]     bus_wdata,
   input  logic              bus_rd,
   output logic [DW-1:0]     bus_rdata,
   output logic              soft_rst_o,
   output logic              irq_o
);
   if (IND_W > DW) begin : g_bad_w
      $error("indirect width exceeds bus width");
   end
   if (IDX_W > DW || IND_NUM <= LOCK_IDX_B || DIR_NUM <= CTRL_WORD) begin : g_bad_n
      $error("register counts too small for fixed roles");
   end

   logic [WSEL_W-1:0]  word;
   logic [DIR_NUM-1:0] dir_we;
   logic               port_we;
   logic               soft_rst;
   logic [DW-1:0]      words [DIR_NUM];
   logic [IND_W-1:0]   ind [IND_NUM];
   logic [IDX_W-1:0]   ptr;
   logic [DW-1:0]      rd_mux;

   codec_bus_decode #(.DW(DW), .DIR_NUM(DIR_NUM)) u_dec (
      .addr_i(bus_addr), .we_i(bus_we), .wdata_i(bus_wdata),
      .word_o(word), .dir_we_o(dir_we), .port_we_o(port_we), .soft_rst_o(soft_rst));

   codec_direct_regs #(.DW(DW), .DIR_NUM(DIR_NUM)) u_dir (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst),
      .dir_we_i(dir_we), .wdata_i(bus_wdata), .words_o(words));

   assign ptr = words[PTR_WORD][IDX_W-1:0];

   codec_indirect_regs #(.IND_NUM(IND_NUM), .IND_W(IND_W)) u_ind (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst),
      .wr_en_i(port_we), .idx_i(ptr), .wdata_i(bus_wdata[IND_W-1:0]), .bytes_o(ind));

   always_comb begin
      if (word == WSEL_W'(PORT_WORD))
         rd_mux = (ptr == IDX_W'(RAZ_IDX)) ? '0 : DW'(ind[ptr]);
      else
         rd_mux = words[word];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   assign soft_rst_o = soft_rst;
   assign irq_o      = 1'b0;

   // R4: zero-read entry
   a_r4_raz_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && word == WSEL_W'(PORT_WORD) && ptr == IDX_W'(RAZ_IDX)) |=> (bus_rdata == '0));
   // R3: port reads are zero-extended
   a_r3_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && word == WSEL_W'(PORT_WORD)) |=> (bus_rdata[DW-1:IND_W] == '0));
   // R8: dropped word reads zero
   a_r8_drop_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && word == WSEL_W'(DROP_WORD)) |=> (bus_rdata == '0));
   // R1: no read strobe, read data holds
   a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_codec_ctrl_regs.sv
module test_codec_ctrl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        soft_rst_o;
   logic        irq_o;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;   // 125 MHz

   codec_ctrl_regs i_codec_ctrl_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .soft_rst_o(soft_rst_o), .irq_o(irq_o));

   // {op(1: 0=write,1=read-check), byte addr(6), data(32), expect(32), req(8)}
   localparam int NV = 25;
   localparam logic [78:0] VEC [NV] = '{
      {1'b0, 6'h0C, 32'hDEADBEEF, 32'h0, 8'd1},        // R1 word 3
      {1'b1, 6'h0C, 32'h0, 32'hDEADBEEF, 8'd1},        // R1
      {1'b0, 6'h3C, 32'h12345678, 32'h0, 8'd1},        // R1 word 15
      {1'b1, 6'h3C, 32'h0, 32'h12345678, 8'd1},        // R1
      {1'b0, 6'h08, 32'hFFFFFFFF, 32'h0, 8'd8},        // R8 drop
      {1'b1, 6'h08, 32'h0, 32'h0, 8'd8},               // R8
      {1'b0, 6'h00, 32'hFFFFFFE5, 32'h0, 8'd2},        // R2 pointer 5
      {1'b1, 6'h00, 32'h0, 32'hFFFFFFE5, 8'd2},        // R2 full readback
      {1'b0, 6'h04, 32'h123456C3, 32'h0, 8'd3},        // R3 store byte
      {1'b1, 6'h04, 32'h0, 32'h000000C3, 8'd3},        // R3 zero-extended
      {1'b0, 6'h00, 32'h3, 32'h0, 8'd4},               // R4 pointer 3
      {1'b0, 6'h04, 32'h77, 32'h0, 8'd4},              // R4
      {1'b1, 6'h04, 32'h0, 32'h0, 8'd4},               // R4 reads zero
      {1'b0, 6'h00, 32'd11, 32'h0, 8'd5},              // R5 pointer 11
      {1'b0, 6'h04, 32'h55, 32'h0, 8'd5},              // R5
      {1'b1, 6'h04, 32'h0, 32'h0, 8'd5},               // R5 unchanged
      {1'b0, 6'h00, 32'd25, 32'h0, 8'd5},              // R5 pointer 25
      {1'b0, 6'h04, 32'h11, 32'h0, 8'd5},              // R5
      {1'b1, 6'h04, 32'h0, 32'hA0, 8'd5},              // R5 keeps A0
      {1'b0, 6'h00, 32'd12, 32'h0, 8'd6},              // R6 pointer 12
      {1'b0, 6'h04, 32'hFF, 32'h0, 8'd6},              // R6
      {1'b1, 6'h04, 32'h0, 32'hCA, 8'd6},              // R6 bit 6 kept
      {1'b0, 6'h04, 32'h00, 32'h0, 8'd6},              // R6
      {1'b1, 6'h04, 32'h0, 32'h8A, 8'd6},              // R6 bit 6 cleared
      {1'b0, 6'h00, 32'h25, 32'h0, 8'd2}               // R2 0x25 -> pointer 5
   };

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic ind_chk(input string req, input int idx, input logic [31:0] exp);
      wr(6'h00, 32'(idx));
      rd_chk(req, 6'h04, exp);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R7 reset state
      chk("R7 rdata", bus_rdata, 32'h0);
      rd_chk("R7 word0", 6'h00, 32'h0);
      rd_chk("R7 word4", 6'h10, 32'h0);
      rd_chk("R7 word9", 6'h24, 32'h0);
      ind_chk("R7 ind0", 0, 32'h0);
      ind_chk("R7 ind12", 12, 32'h8A);
      ind_chk("R7 ind25", 25, 32'hA0);
      ind_chk("R7 ind31", 31, 32'h0);
      wr(6'h00, 32'h0);

      // vector table
      for (int k = 0; k < NV; k++) begin
         logic [78:0] e;
         e = VEC[k];
         if (e[78] == 1'b0) wr(e[77:72], e[71:40]);
         else begin
            rd(e[77:72], v);
            chk($sformatf("R%0d vec%0d", e[7:0], k), v, e[39:8]);
         end
      end
      rd_chk("R2 pointer low bits", 6'h04, 32'hC3);

      // R1 hold: no strobe, rdata unchanged
      @(negedge clk); bus_addr = 6'h0C;
      @(negedge clk);
      chk("R1 hold", bus_rdata, 32'hC3);

      // R10 control write without reset bit
      wr(6'h10, 32'hFFFF_00FE);
      rd_chk("R10 ctrl mask", 6'h10, 32'h7E);
      rd_chk("R10 word3 kept", 6'h0C, 32'hDEADBEEF);
      rd_chk("R10 ptr kept", 6'h00, 32'h25);
      rd_chk("R10 ind5 kept", 6'h04, 32'hC3);

      // R9 soft reset
      wr(6'h00, 32'd7);
      wr(6'h04, 32'h99);
      @(negedge clk);
      bus_addr = 6'h10; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b1;
      #1 chk("R9 strobe", {31'b0, soft_rst_o}, 32'h1);
      @(negedge clk);
      bus_we = 1'b0;
      #1 chk("R9 strobe low", {31'b0, soft_rst_o}, 32'h0);
      rd_chk("R9 ctrl stored", 6'h10, 32'h7F);
      rd_chk("R9 word3 cleared", 6'h0C, 32'h0);
      rd_chk("R9 word15 cleared", 6'h3C, 32'h0);
      rd_chk("R9 ptr cleared", 6'h00, 32'h0);
      ind_chk("R9 ind7 cleared", 7, 32'h0);
      ind_chk("R9 ind5 cleared", 5, 32'h0);
      ind_chk("R9 ind12 restored", 12, 32'h8A);
      ind_chk("R9 ind25 restored", 25, 32'hA0);

      // R11
      chk("R11 irq", {31'b0, irq_o}, 32'h0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule